// File: doc/BRIEF.md
# CPU-Space Breakpoint Acknowledge Responder

This block is a bus slave on an asynchronous, strobe-based processor bus. It watches every bus cycle for CPU-space accesses, which are marked by function code 7. Inside CPU space it decodes the four-bit type field on address bits 19..16. When a breakpoint acknowledge read arrives, it returns a replacement instruction word from an eight-entry table. The entry is chosen by the breakpoint number on address bits 4..2. If that entry holds no valid word, the block ends the cycle with a bus error instead of an acknowledge.

Address bit 1 marks a breakpoint as hardware (1) or software (0). The block shows that bit while it answers, and it keeps one count of acknowledged software breakpoints and one of acknowledged hardware breakpoints. The interrupt acknowledge, low-power stop broadcast and base-register access types are each flagged for one clock and are not answered. Reserved types and ordinary cycles get no answer at all.

Bus inputs go through a two-flop synchroniser before decoding. The table is loaded through a simple synchronous write port.

Top module: `bkpt_ack_responder`

## Requirements
- R1: After reset, dsack_n_o and berr_n_o are high, data_oe_o is low, both counters read 0 and every table entry is invalid, so a breakpoint read ends in a bus error.
- R2: A cycle whose function code is not 3'b111 gets no acknowledge, no bus error and no flag.
- R3: A read with function code 3'b111, type 4'h0, address bits 15..5 and bit 0 all zero, and a valid entry at the index on address bits 4..2 drives that entry's word on data_o with data_oe_o high and dsack_n_o low.
- R4: The same cycle with an invalid entry drives berr_n_o low and leaves dsack_n_o high and data_oe_o low.
- R5: While the block answers, bkpt_hw_o equals address bit 1. An acknowledge with bit 1 = 0 adds one to sw_count_o, and one with bit 1 = 1 adds one to hw_count_o. Bus-error endings change neither count.
- R6: In CPU space, type 4'h3 raises flag_lpstop_o, type 4'h7 raises flag_mbar_o and type 4'hF raises flag_iack_o, each for exactly one clock. None of these types is answered.
- R7: A CPU-space cycle gets no response and no flag if it has a reserved type, if it is a type-0 write, or if it is a type-0 cycle with a nonzero bit among address bits 15..5 or bit 0.
- R8: Once a strobe goes high, the response stays through two more rising edges and is released on the third rising edge.
- R9: With both strobes low, a flag appears after the third rising edge and the response after the fourth.
- R10: The table entry is read in the decode clock. A table write landing in that same clock does not change the word or the acknowledge/error choice for the current cycle, and the driven word stays stable until release.
- R11: When tbl_we_i is high on a rising edge, the entry at tbl_idx_i takes tbl_word_i and the valid bit tbl_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fc_i | input | 3 | Function code |
| addr_i | input | 20 | Address bits 19..0 |
| as_n_i | input | 1 | Address strobe, active low |
| ds_n_i | input | 1 | Data strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| tbl_we_i | input | 1 | Table write enable |
| tbl_idx_i | input | 3 | Table entry to write |
| tbl_word_i | input | 16 | Instruction word to store |
| tbl_valid_i | input | 1 | Valid bit to store |
| data_o | output | 16 | Returned instruction word |
| data_oe_o | output | 1 | Data bus drive enable |
| dsack_n_o | output | 1 | Data-size acknowledge, active low |
| berr_n_o | output | 1 | Bus error, active low |
| bkpt_hw_o | output | 1 | Hardware breakpoint indication while answering |
| flag_iack_o | output | 1 | Interrupt acknowledge cycle seen |
| flag_lpstop_o | output | 1 | Low-power stop broadcast seen |
| flag_mbar_o | output | 1 | Base-register access seen |
| sw_count_o | output | 8 | Acknowledged software breakpoints |
| hw_count_o | output | 8 | Acknowledged hardware breakpoints |

## Verification
The table write port and the breakpoint lookup can act in the same clock. The bench provokes this by timing a write to the indexed entry so that it lands on the decode clock, which it knows from the synchroniser depth. The new contents flip the valid bit and change the word. The bench judges the cycle by expecting the old word and the old acknowledge/error choice at the response, and the new contents on the next cycle that uses that entry.

// File: rtl/bkpt_pkg.sv
// Shared constants and types for the breakpoint acknowledge responder.
package bkpt_pkg;
    localparam logic [2:0] FC_CPU_SPACE = 3'b111;
    localparam logic [3:0] TYPE_BKPT    = 4'h0;
    localparam logic [3:0] TYPE_LPSTOP  = 4'h3;
    localparam logic [3:0] TYPE_MBAR    = 4'h7;
    localparam logic [3:0] TYPE_IACK    = 4'hF;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_DECODE      = 2'd1,
        ST_DRIVE       = 2'd2,
        ST_WAIT_NEGATE = 2'd3
    } rsp_state_t;
endpackage

// File: rtl/bkpt_sync.sv
// Multi-stage synchroniser for a vector of asynchronous bus inputs.
// Assumes each bit is sampled on its own. Bus inputs must be held stable
// long enough for the decoder to see a coherent word.
module bkpt_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first flop captures the raw asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // later flops let a metastable value settle
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bkpt_table.sv
// Replacement-instruction table: one word and one valid bit per breakpoint.
// Writes take effect on the clock edge. Reads are combinational, so a read
// in the same clock as a write still returns the old contents.
module bkpt_table #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned WORD_W  = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_valid
);
    logic [WORD_W-1:0] word_q [ENTRIES];
    logic              vld_q  [ENTRIES];

    genvar e;
    generate
        for (e = 0; e < ENTRIES; e++) begin : g_entry
            // load one entry from the write port, cleared to invalid on reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q[e] <= '0;
                    vld_q[e]  <= 1'b0;
                end else if (wr_en && wr_idx == IDX_W'(e)) begin
                    word_q[e] <= wr_word;
                    vld_q[e]  <= wr_valid;
                end
            end
        end
    endgenerate

    assign rd_word  = word_q[rd_idx];
    assign rd_valid = vld_q[rd_idx];

    // R11
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld_q[$past(wr_idx)] == $past(wr_valid)) &&
                  (word_q[$past(wr_idx)] == $past(wr_word)));
endmodule

// File: rtl/bkpt_fsm.sv
// Cycle decoder and response sequencer. Works on bus signals that have
// already been synchronised. It captures the cycle fields when both
// strobes are low, decodes them for one clock, then answers a breakpoint
// read or waits for the strobes to negate.
module bkpt_fsm
    import bkpt_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_s,
    input  logic              ds_s,
    input  logic              rw_s,
    input  logic [2:0]        fc_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [WORD_W-1:0] tbl_word,
    input  logic              tbl_valid,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic              rsp_ack,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_word,
    output logic              rsp_hw,
    output logic              flag_iack,
    output logic              flag_lpstop,
    output logic              flag_mbar,
    output logic [CNT_W-1:0]  sw_cnt,
    output logic [CNT_W-1:0]  hw_cnt
);
    localparam int unsigned TYPE_LSB = ADDR_W - 4;
    localparam int unsigned T_POS    = 1;
    localparam int unsigned IDX_LSB  = 2;
    localparam int unsigned FILL_LSB = IDX_LSB + IDX_W;

    rsp_state_t        state_q, state_d;
    logic [3:0]        type_q;
    logic [IDX_W-1:0]  idx_q;
    logic              t_q, rw_q, fc_ok_q, fill_ok_q, hit_q;
    logic [WORD_W-1:0] word_q;
    logic              strobes_on, strobe_off, bkpt_match, decode_cpu;

    assign strobes_on = !as_s && !ds_s;
    assign strobe_off = as_s || ds_s;
    assign bkpt_match = fc_ok_q && (type_q == TYPE_BKPT) && rw_q && fill_ok_q;

    // next-state selection for the response sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (strobes_on) state_d = ST_DECODE;
            ST_DECODE:      state_d = bkpt_match ? ST_DRIVE : ST_WAIT_NEGATE;
            ST_DRIVE:       if (strobe_off) state_d = ST_IDLE;
            ST_WAIT_NEGATE: if (strobe_off) state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // state register, field capture, table lookup latch and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            type_q    <= '0;
            idx_q     <= '0;
            t_q       <= 1'b0;
            rw_q      <= 1'b0;
            fc_ok_q   <= 1'b0;
            fill_ok_q <= 1'b0;
            hit_q     <= 1'b0;
            word_q    <= '0;
            sw_cnt    <= '0;
            hw_cnt    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && strobes_on) begin
                type_q    <= addr_s[ADDR_W-1:TYPE_LSB];
                idx_q     <= addr_s[FILL_LSB-1:IDX_LSB];
                t_q       <= addr_s[T_POS];
                rw_q      <= rw_s;
                fc_ok_q   <= (fc_s == FC_CPU_SPACE);
                fill_ok_q <= (addr_s[TYPE_LSB-1:FILL_LSB] == '0) && !addr_s[0];
            end
            if (state_q == ST_DECODE && bkpt_match) begin
                hit_q  <= tbl_valid;
                word_q <= tbl_word;
                if (tbl_valid && !t_q) sw_cnt <= sw_cnt + 1'b1;
                if (tbl_valid &&  t_q) hw_cnt <= hw_cnt + 1'b1;
            end
        end
    end

    assign tbl_idx     = idx_q;
    assign rsp_ack     = (state_q == ST_DRIVE) && hit_q;
    assign rsp_err     = (state_q == ST_DRIVE) && !hit_q;
    assign rsp_word    = word_q;
    assign rsp_hw      = (state_q == ST_DRIVE) && t_q;
    assign decode_cpu  = (state_q == ST_DECODE) && fc_ok_q;
    assign flag_iack   = decode_cpu && (type_q == TYPE_IACK);
    assign flag_lpstop = decode_cpu && (type_q == TYPE_LPSTOP);
    assign flag_mbar   = decode_cpu && (type_q == TYPE_MBAR);

    // R9
    drive_after_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && $past(state_q) != ST_DRIVE) |-> $past(state_q) == ST_DECODE);
    // R5
    sw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_cnt != $past(sw_cnt)) |-> (sw_cnt == CNT_W'($past(sw_cnt) + 1'b1)));
    // R5
    hw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_cnt != $past(hw_cnt)) |-> (hw_cnt == CNT_W'($past(hw_cnt) + 1'b1)));
    // R6
    flag_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_iack, flag_lpstop, flag_mbar}));
    // R10
    word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && $past(state_q) == ST_DRIVE) |-> $stable(word_q));
endmodule

// File: rtl/bkpt_ack_responder.sv
// Top level: synchronises the bus, decodes CPU-space cycles, answers
// breakpoint acknowledge reads from the table and flags the other types.
// Assumes the bus master holds the function code, address and read/write
// stable while the strobes are low.
module bkpt_ack_responder #(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned STAGES  = 2,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        fc_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              as_n_i,
    input  logic              ds_n_i,
    input  logic              rw_i,
    input  logic              tbl_we_i,
    input  logic [IDX_W-1:0]  tbl_idx_i,
    input  logic [WORD_W-1:0] tbl_word_i,
    input  logic              tbl_valid_i,
    output logic [WORD_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              dsack_n_o,
    output logic              berr_n_o,
    output logic              bkpt_hw_o,
    output logic              flag_iack_o,
    output logic              flag_lpstop_o,
    output logic              flag_mbar_o,
    output logic [CNT_W-1:0]  sw_count_o,
    output logic [CNT_W-1:0]  hw_count_o
);
    localparam int unsigned SYNC_W = 3 + 3 + ADDR_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {2'b11, {(SYNC_W-2){1'b0}}};

    logic [SYNC_W-1:0] sync_q;
    logic              as_s, ds_s, rw_s;
    logic [2:0]        fc_s;
    logic [ADDR_W-1:0] addr_s;
    logic [IDX_W-1:0]  rd_idx;
    logic [WORD_W-1:0] rd_word, rsp_word;
    logic              rd_valid, rsp_ack, rsp_err;

    bkpt_sync #(.WIDTH(SYNC_W), .STAGES(STAGES), .RST_VAL(SYNC_RST)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .d({as_n_i, ds_n_i, rw_i, fc_i, addr_i}),
        .q(sync_q)
    );
    assign {as_s, ds_s, rw_s, fc_s, addr_s} = sync_q;

    bkpt_table #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) table_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we_i), .wr_idx(tbl_idx_i), .wr_word(tbl_word_i), .wr_valid(tbl_valid_i),
        .rd_idx(rd_idx), .rd_word(rd_word), .rd_valid(rd_valid)
    );

    bkpt_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .as_s(as_s), .ds_s(ds_s), .rw_s(rw_s), .fc_s(fc_s), .addr_s(addr_s),
        .tbl_word(rd_word), .tbl_valid(rd_valid), .tbl_idx(rd_idx),
        .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_word(rsp_word), .rsp_hw(bkpt_hw_o),
        .flag_iack(flag_iack_o), .flag_lpstop(flag_lpstop_o), .flag_mbar(flag_mbar_o),
        .sw_cnt(sw_count_o), .hw_cnt(hw_count_o)
    );

    assign dsack_n_o = !rsp_ack;
    assign berr_n_o  = !rsp_err;
    assign data_oe_o = rsp_ack;
    assign data_o    = rsp_ack ? rsp_word : '0;

    // R4
    ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dsack_n_o && !berr_n_o));
    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(as_s) || $past(ds_s)) && (as_s || ds_s) |-> dsack_n_o && berr_n_o);
    // R6
    flag_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_iack_o || flag_lpstop_o || flag_mbar_o) |=> dsack_n_o && berr_n_o);
endmodule

// File: tb/bkpt_ack_responder_tb_top.sv
`timescale 1ns/1ps
module bkpt_ack_responder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fc_i = '0;
    logic [19:0] addr_i = '0;
    logic        as_n_i = 1'b1, ds_n_i = 1'b1, rw_i = 1'b1;
    logic        tbl_we_i = 1'b0;
    logic [2:0]  tbl_idx_i = '0;
    logic [15:0] tbl_word_i = '0;
    logic        tbl_valid_i = 1'b0;
    logic [15:0] data_o;
    logic        data_oe_o, dsack_n_o, berr_n_o, bkpt_hw_o;
    logic        flag_iack_o, flag_lpstop_o, flag_mbar_o;
    logic [7:0]  sw_count_o, hw_count_o;

    int unsigned n_chk = 0, n_fail = 0;
    logic [15:0] m_word [8];
    logic        m_vld  [8];
    logic [7:0]  m_sw = 0, m_hw = 0;

    always #4 clk = ~clk;

    bkpt_ack_responder dut_i (
        .clk(clk), .rst_n(rst_n), .fc_i(fc_i), .addr_i(addr_i),
        .as_n_i(as_n_i), .ds_n_i(ds_n_i), .rw_i(rw_i),
        .tbl_we_i(tbl_we_i), .tbl_idx_i(tbl_idx_i), .tbl_word_i(tbl_word_i),
        .tbl_valid_i(tbl_valid_i), .data_o(data_o), .data_oe_o(data_oe_o),
        .dsack_n_o(dsack_n_o), .berr_n_o(berr_n_o), .bkpt_hw_o(bkpt_hw_o),
        .flag_iack_o(flag_iack_o), .flag_lpstop_o(flag_lpstop_o), .flag_mbar_o(flag_mbar_o),
        .sw_count_o(sw_count_o), .hw_count_o(hw_count_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] mk_addr(input logic [3:0] ty, input logic [2:0] idx,
                                            input logic t, input logic bad);
        return {ty, bad ? 11'h010 : 11'h000, idx, t, 1'b0};
    endfunction

    function automatic logic [2:0] exp_flags(input logic [2:0] fc, input logic [3:0] ty);
        if (fc != 3'b111) return 3'b000;
        return {ty == 4'hF, ty == 4'h3, ty == 4'h7};
    endfunction

    task automatic write_entry(input logic [2:0] idx, input logic [15:0] w, input logic v);
        @(negedge clk);
        tbl_we_i = 1'b1; tbl_idx_i = idx; tbl_word_i = w; tbl_valid_i = v;
        @(negedge clk);
        tbl_we_i = 1'b0;
        m_word[idx] = w; m_vld[idx] = v;
    endtask

    // one full bus cycle; collide puts a table write on the decode clock
    task automatic bus_cycle(input logic [2:0] fc, input logic [3:0] ty, input logic [2:0] idx,
                             input logic t, input logic rd, input logic bad,
                             input logic collide, input logic [15:0] cw);
        logic match, e_ack, e_err;
        logic [15:0] e_word;
        string tag;
        match  = (fc == 3'b111) && (ty == 4'h0) && rd && !bad;
        e_ack  = match && m_vld[idx];
        e_err  = match && !m_vld[idx];
        e_word = e_ack ? m_word[idx] : 16'h0;
        if (collide)      tag = "R10";
        else if (e_ack)   tag = "R3";
        else if (e_err)   tag = "R4";
        else if (fc != 3'b111) tag = "R2";
        else              tag = "R7";
        @(negedge clk);
        fc_i = fc; addr_i = mk_addr(ty, idx, t, bad); rw_i = rd;
        as_n_i = 1'b0; ds_n_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (collide) begin
            tbl_we_i = 1'b1; tbl_idx_i = idx; tbl_word_i = cw; tbl_valid_i = !m_vld[idx];
        end
        // R6 flags on the decode clock, R9 no response yet
        chk("R6", {flag_iack_o, flag_lpstop_o, flag_mbar_o}, exp_flags(fc, ty));
        chk("R9", {dsack_n_o, berr_n_o}, 2'b11);
        @(posedge clk);
        @(negedge clk);
        tbl_we_i = 1'b0;
        if (collide) begin m_word[idx] = cw; m_vld[idx] = !m_vld[idx]; end
        if (e_ack && !t) m_sw++;
        if (e_ack && t)  m_hw++;
        chk(tag, {!dsack_n_o, !berr_n_o, data_oe_o}, {e_ack, e_err, e_ack});
        chk(tag, data_o, e_word);
        chk("R5", bkpt_hw_o, match && t);
        chk("R5", {sw_count_o, hw_count_o}, {m_sw, m_hw});
        chk("R6", {flag_iack_o, flag_lpstop_o, flag_mbar_o}, 3'b000);
        @(negedge clk);
        chk("R10", {data_o, dsack_n_o, berr_n_o}, {e_word, !e_ack, !e_err});
        as_n_i = 1'b1; ds_n_i = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8", {dsack_n_o, berr_n_o}, {!e_ack, !e_err});
        @(posedge clk);
        @(negedge clk);
        chk("R8", {dsack_n_o, berr_n_o, data_oe_o}, 3'b110);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 8; i++) begin m_word[i] = '0; m_vld[i] = 1'b0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {dsack_n_o, berr_n_o, data_oe_o}, 3'b110);
        chk("R1", {sw_count_o, hw_count_o}, 16'h0);
        bus_cycle(3'b111, 4'h0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0); // R1 empty table -> R4
        // R11 load and use
        write_entry(3'd5, 16'h4E71, 1'b1);
        bus_cycle(3'b111, 4'h0, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0); // R11 / R3
        bus_cycle(3'b111, 4'h0, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0); // R5 hardware
        bus_cycle(3'b101, 4'h0, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0); // R2
        bus_cycle(3'b111, 4'h0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0); // R7 write
        bus_cycle(3'b111, 4'h0, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0); // R7 filler
        bus_cycle(3'b111, 4'h5, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0); // R7 reserved
        bus_cycle(3'b111, 4'hF, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0); // R6 iack
        bus_cycle(3'b111, 4'h3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0); // R6 lpstop
        bus_cycle(3'b111, 4'h7, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0); // R6 mbar
        bus_cycle(3'b111, 4'h0, 3'd5, 1'b0, 1'b1, 1'b0, 1'b1, 16'hBEEF); // R10 valid->invalid
        bus_cycle(3'b111, 4'h0, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0); // R10 new contents: berr
        bus_cycle(3'b111, 4'h0, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 16'h1234); // R10 invalid->valid
        bus_cycle(3'b111, 4'h0, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0); // R10 then acknowledged
        for (int n = 0; n < 120; n++) begin
            logic [2:0] fc; logic [3:0] ty; logic [2:0] idx;
            if ($urandom_range(3) == 0)
                write_entry(3'($urandom_range(7)), 16'($urandom), 1'($urandom_range(1)));
            fc  = ($urandom_range(4) == 0) ? 3'($urandom_range(6)) : 3'b111;
            case ($urandom_range(5))
                0, 1, 2: ty = 4'h0;
                3:       ty = 4'h3;
                4:       ty = 4'hF;
                default: ty = 4'($urandom_range(15));
            endcase
            idx = 3'($urandom_range(7));
            bus_cycle(fc, ty, idx, 1'($urandom_range(1)), ($urandom_range(7) != 0),
                      ($urandom_range(9) == 0), ($urandom_range(7) == 0), 16'($urandom));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule